// File: doc/BRIEF.md
# DDR SDRAM Command Timing Checker

This block sits beside the command bus of a four-bank double-data-rate SDRAM and inspects one command on every rising clock edge. It decodes the command from clock enable, chip select, the three strobes, the bank address and A10. It keeps an open or closed flag and a set of countdown timers for every bank, plus a few bus-wide timers. When a command breaks a bank-state rule or comes too soon after an earlier command, it reports a violation code.

All spacing limits are elaboration parameters counted in whole clocks, and so is the burst length. The write data of a burst is taken to occupy the `BURST_LEN/2` clocks that follow the write command. The code for each cycle is registered, so it appears on the edge that samples the command and lasts one cycle. A separate sticky pair keeps the first violation until reset. Integration and verification environments use it as a protocol monitor for a memory controller's command stream.

Top module: `ddr_cmd_checker`

## Requirements
- R1: A command is taken only when `cke` is high in the sampling cycle and in the cycle before, and `csN` is low. With {rasN,casN,weN}: 000 mode-register write, 001 refresh, 011 activate, 101 read, 100 write, 110 burst stop, 010 precharge, 111 no operation. The bank index is {ba[1],ba[0]} read as a binary number 0 to 3. A deselected or clock-disabled cycle is ignored.
- R2: `violValid`/`violCode` are registered. They show the result of the command sampled at a clock edge after that same edge and hold it for one cycle. A legal command or an ignored cycle gives `violValid`=0 and code 0, and reset clears all outputs and closes all banks.
- R3: Any command other than no-operation issued fewer than `T_MRD` clocks after a mode-register write gives code 1.
- R4: Any command other than no-operation issued fewer than `T_RFC` clocks after a refresh gives code 2.
- R5: A mode-register write or refresh while any bank is open gives code 3.
- R6: A read or write to a closed bank gives code 4. An activate to a bank that is already open gives code 5.
- R7: A read or write fewer than `T_RCD` clocks after its bank's activate gives code 6. A precharge that closes an open bank fewer than `T_RAS` clocks after its activate gives code 7.
- R8: An activate fewer than `T_RC` clocks after the previous activate of the same bank gives code 8. An activate fewer than `T_RRD` clocks after an activate of a different bank gives code 9.
- R9: An activate fewer than `T_RP` clocks after the precharge that closed its bank gives code 10. After a read or write with auto precharge, an activate of that bank fewer than `BURST_LEN/2+T_RP` clocks later also gives code 10.
- R10: A precharge of a bank fewer than `BURST_LEN/2+T_WR` clocks after a write to it gives code 11. A read fewer than `BURST_LEN/2+T_WTR` clocks after any write gives code 12.
- R11: A read or write issued 1 to `BURST_LEN/2` clocks after a write with auto precharge gives code 13.
- R12: Precharge with A10 high closes every bank whatever `ba` holds. With A10 low it closes only the addressed bank. A10 high on a read or write closes that bank.
- R13: When several rules break in one cycle, `violCode` shows the lowest code. `stickyValid`/`stickyCode` capture the first violation after reset and hold it until reset.
- R14: A burst stop is never flagged except inside the R3 and R4 windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command bus clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Auto-precharge / precharge-all bit |
| violValid | output | 1 | A violation was found in the last sampled command |
| violCode | output | 4 | Lowest violation code of that command, 0 when none |
| stickyValid | output | 1 | A violation has occurred since reset |
| stickyCode | output | 4 | Code of the first violation since reset |

## Verification
Several rules can break on a single command, and the code chosen among them is the point under test. An activate to an open bank that is also inside its row-cycle window must report 5 rather than 8. An activate inside both the row-cycle and auto-precharge recovery windows must report 8 rather than 10. A refresh with an open bank followed by a precharge-all inside the refresh window must report 2 even though the precharge also breaks the active-time rule. The vector table builds these overlaps by timing commands so that two counters are still running at once, and each expected code comes from the priority rule applied to the clock distances.

// File: rtl/ddr_chk_pkg.sv
package ddr_chk_pkg;

  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = 2;
  localparam int VIOL_W    = 4;
  localparam int NUM_VIOL  = 13;

  // violation codes, lower value wins
  localparam int V_MRD      = 1;
  localparam int V_RFC      = 2;
  localparam int V_BUSY     = 3;
  localparam int V_CLOSED   = 4;
  localparam int V_OPEN     = 5;
  localparam int V_RCD      = 6;
  localparam int V_RAS      = 7;
  localparam int V_RC       = 8;
  localparam int V_RRD      = 9;
  localparam int V_RP       = 10;
  localparam int V_WR       = 11;
  localparam int V_WTR      = 12;
  localparam int V_WRA      = 13;

  typedef struct packed {
    logic                act;
    logic                rd;
    logic                wr;
    logic                pre;
    logic                preAll;
    logic                refresh;
    logic                modeSet;
    logic                burstStop;
    logic                autoPre;
    logic [BANK_W-1:0]   bank;
  } cmdStrobe_t;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [BANK_W-1:0] ba,
  input  logic              a10,
  output cmdStrobe_t        stb
);

  logic ckePrev;
  logic live;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ckePrev <= 1'b0;
    else       ckePrev <= cke;
  end

  assign live = ckePrev && cke && !csN;

  always_comb begin
    stb         = '0;
    stb.bank    = ba;
    stb.autoPre = a10;
    if (live) begin
      unique case ({rasN, casN, weN})
        3'b000: stb.modeSet   = 1'b1;
        3'b001: stb.refresh   = 1'b1;
        3'b011: stb.act       = 1'b1;
        3'b101: stb.rd        = 1'b1;
        3'b100: stb.wr        = 1'b1;
        3'b110: stb.burstStop = 1'b1;
        3'b010: begin
          stb.pre    = !a10;
          stb.preAll = a10;
        end
        default: ;
      endcase
    end
  end

  // R1: at most one command kind per cycle
  p_one_cmd_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.act, stb.rd, stb.wr, stb.pre, stb.preAll,
              stb.refresh, stb.modeSet, stb.burstStop}));

endmodule

// File: rtl/ddr_timing_path.sv
module ddr_timing_path
  import ddr_chk_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 5,
  parameter int T_RC      = 9,
  parameter int T_RRD     = 2,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2,
  parameter int T_WTR     = 2,
  parameter int T_RFC     = 6,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        stb,
  output logic [NUM_VIOL:1] violVec,
  output logic              anyOpen
);

  localparam int BURST_CYC = BURST_LEN / 2;
  localparam int SUM_T     = T_RCD + T_RAS + T_RC + T_RRD + T_RP + T_WR
                           + T_WTR + T_RFC + T_MRD + BURST_CYC;
  localparam int CNT_W     = $clog2(SUM_T + 1);

  localparam logic [CNT_W-1:0] L_RCD  = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] L_RAS  = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] L_RC   = CNT_W'(T_RC - 1);
  localparam logic [CNT_W-1:0] L_RRD  = CNT_W'(T_RRD - 1);
  localparam logic [CNT_W-1:0] L_RP   = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] L_APRP = CNT_W'(BURST_CYC + T_RP - 1);
  localparam logic [CNT_W-1:0] L_WR   = CNT_W'(BURST_CYC + T_WR - 1);
  localparam logic [CNT_W-1:0] L_WTR  = CNT_W'(BURST_CYC + T_WTR - 1);
  localparam logic [CNT_W-1:0] L_RFC  = CNT_W'(T_RFC - 1);
  localparam logic [CNT_W-1:0] L_MRD  = CNT_W'(T_MRD - 1);
  localparam logic [CNT_W-1:0] L_WRA  = CNT_W'(BURST_CYC);

  // countdown: load the larger of the reloaded and the remaining distance
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur,
                                            input logic             ld,
                                            input logic [CNT_W-1:0] val);
    logic [CNT_W-1:0] dec;
    dec = (cur != '0) ? cur - CNT_W'(1) : '0;
    if (ld && (val > dec)) return val;
    return dec;
  endfunction

  logic [NUM_BANKS-1:0] bankOpen;
  logic [NUM_BANKS-1:0] rwClosedB, actOpenB, rcdB, rasB, rcB, rpB, wrB;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [BANK_W-1:0] BID = BANK_W'(b);
    logic sel, actB, rwB, closeB, autoB;
    logic openQ;
    logic [CNT_W-1:0] rcdCnt, rasCnt, rcCnt, rpCnt, wrCnt;

    always_comb begin
      sel    = (stb.bank == BID);
      actB   = stb.act && sel;
      rwB    = (stb.rd || stb.wr) && sel;
      closeB = (stb.pre && sel) || stb.preAll;
      autoB  = rwB && stb.autoPre;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        openQ  <= 1'b0;
        rcdCnt <= '0;
        rasCnt <= '0;
        rcCnt  <= '0;
        rpCnt  <= '0;
        wrCnt  <= '0;
      end else begin
        if (actB)                 openQ <= 1'b1;
        else if (closeB || autoB) openQ <= 1'b0;
        rcdCnt <= step(rcdCnt, actB, L_RCD);
        rasCnt <= step(rasCnt, actB, L_RAS);
        rcCnt  <= step(rcCnt,  actB, L_RC);
        rpCnt  <= step(rpCnt, (closeB && openQ) || autoB,
                       autoB ? L_APRP : L_RP);
        wrCnt  <= step(wrCnt, stb.wr && sel, L_WR);
      end
    end

    assign bankOpen[b]  = openQ;
    assign rwClosedB[b] = rwB && !openQ;
    assign actOpenB[b]  = actB && openQ;
    assign rcdB[b]      = rwB && (rcdCnt != '0);
    assign rasB[b]      = closeB && openQ && (rasCnt != '0);
    assign rcB[b]       = actB && (rcCnt != '0);
    assign rpB[b]       = actB && (rpCnt != '0);
    assign wrB[b]       = closeB && (wrCnt != '0);

    // R12: a precharge-all leaves this bank closed on the next cycle
    p_pre_all_closes_r12: assert property (@(posedge clk) disable iff (!rstN)
      stb.preAll |=> !openQ);
  end

  logic [CNT_W-1:0]  rrdCnt, wtrCnt, rfcCnt, mrdCnt, wraCnt;
  logic [BANK_W-1:0] lastActBank;
  logic              anyCmd;

  assign anyCmd = stb.act || stb.rd || stb.wr || stb.pre || stb.preAll ||
                  stb.refresh || stb.modeSet || stb.burstStop;
  assign anyOpen = |bankOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrdCnt      <= '0;
      wtrCnt      <= '0;
      rfcCnt      <= '0;
      mrdCnt      <= '0;
      wraCnt      <= '0;
      lastActBank <= '0;
    end else begin
      rrdCnt <= step(rrdCnt, stb.act, L_RRD);
      wtrCnt <= step(wtrCnt, stb.wr, L_WTR);
      rfcCnt <= step(rfcCnt, stb.refresh, L_RFC);
      mrdCnt <= step(mrdCnt, stb.modeSet, L_MRD);
      wraCnt <= step(wraCnt, stb.wr && stb.autoPre, L_WRA);
      if (stb.act) lastActBank <= stb.bank;
    end
  end

  always_comb begin
    violVec           = '0;
    violVec[V_MRD]    = anyCmd && (mrdCnt != '0);
    violVec[V_RFC]    = anyCmd && (rfcCnt != '0);
    violVec[V_BUSY]   = (stb.modeSet || stb.refresh) && anyOpen;
    violVec[V_CLOSED] = |rwClosedB;
    violVec[V_OPEN]   = |actOpenB;
    violVec[V_RCD]    = |rcdB;
    violVec[V_RAS]    = |rasB;
    violVec[V_RC]     = |rcB;
    violVec[V_RRD]    = stb.act && (rrdCnt != '0) && (stb.bank != lastActBank);
    violVec[V_RP]     = |rpB;
    violVec[V_WR]     = |wrB;
    violVec[V_WTR]    = stb.rd && (wtrCnt != '0);
    violVec[V_WRA]    = (stb.rd || stb.wr) && (wraCnt != '0);
  end

endmodule

// File: rtl/ddr_viol_report.sv
module ddr_viol_report
  import ddr_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_VIOL:1] violVec,
  output logic              violValid,
  output logic [VIOL_W-1:0] violCode,
  output logic              stickyValid,
  output logic [VIOL_W-1:0] stickyCode
);

  logic [VIOL_W-1:0] lowCode;

  always_comb begin
    lowCode = '0;
    for (int i = NUM_VIOL; i >= 1; i--) begin
      if (violVec[i]) lowCode = VIOL_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violValid   <= 1'b0;
      violCode    <= '0;
      stickyValid <= 1'b0;
      stickyCode  <= '0;
    end else begin
      violValid <= (lowCode != '0);
      violCode  <= lowCode;
      if (!stickyValid && (lowCode != '0)) begin
        stickyValid <= 1'b1;
        stickyCode  <= lowCode;
      end
    end
  end

  // R13: the sticky record never changes once taken
  p_sticky_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    stickyValid |=> stickyValid && $stable(stickyCode));

  // R13: every reported violation is reflected in the sticky flag
  p_sticky_seen_r13: assert property (@(posedge clk) disable iff (!rstN)
    violValid |-> stickyValid);

endmodule

// File: rtl/ddr_cmd_checker.sv
module ddr_cmd_checker
  import ddr_chk_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 5,
  parameter int T_RC      = 9,
  parameter int T_RRD     = 2,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2,
  parameter int T_WTR     = 2,
  parameter int T_RFC     = 6,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cke,
  input  logic       csN,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  input  logic [1:0] ba,
  input  logic       a10,
  output logic       violValid,
  output logic [3:0] violCode,
  output logic       stickyValid,
  output logic [3:0] stickyCode
);

  cmdStrobe_t        stb;
  logic [NUM_VIOL:1] violVec;
  logic              anyOpen;
  logic              cmdSeen;

  ddr_cmd_decode u_decode (
    .clk  (clk),
    .rstN (rstN),
    .cke  (cke),
    .csN  (csN),
    .rasN (rasN),
    .casN (casN),
    .weN  (weN),
    .ba   (ba),
    .a10  (a10),
    .stb  (stb)
  );

  ddr_timing_path #(
    .T_RCD     (T_RCD),
    .T_RAS     (T_RAS),
    .T_RC      (T_RC),
    .T_RRD     (T_RRD),
    .T_RP      (T_RP),
    .T_WR      (T_WR),
    .T_WTR     (T_WTR),
    .T_RFC     (T_RFC),
    .T_MRD     (T_MRD),
    .BURST_LEN (BURST_LEN)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .violVec (violVec),
    .anyOpen (anyOpen)
  );

  ddr_viol_report u_report (
    .clk         (clk),
    .rstN        (rstN),
    .violVec     (violVec),
    .violValid   (violValid),
    .violCode    (violCode),
    .stickyValid (stickyValid),
    .stickyCode  (stickyCode)
  );

  assign cmdSeen = stb.act || stb.rd || stb.wr || stb.pre || stb.preAll ||
                   stb.refresh || stb.modeSet || stb.burstStop;

  // R3: a command right after a mode-register write reports code 1
  if (T_MRD >= 2) begin : g_mrd_chk
    p_mrd_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
      (stb.modeSet ##1 cmdSeen) |=> violValid && (violCode == 4'd1));
  end

  // R4: a command right after a refresh reports code 2 or lower
  if (T_RFC >= 2) begin : g_rfc_chk
    p_rfc_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
      (stb.refresh ##1 cmdSeen) |=> violValid && (violCode <= 4'd2));
  end

  // R5: refresh or mode write with an open bank never passes silently
  p_busy_bank_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.refresh || stb.modeSet) && anyOpen) |=>
      violValid && (violCode <= 4'd3));

endmodule

// File: tb/tb_ddr_cmd_checker.sv
module tb_ddr_cmd_checker;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cke, csN, rasN, casN, weN, a10;
  logic [1:0] ba;
  logic       violValid, stickyValid;
  logic [3:0] violCode, stickyCode;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ddr_cmd_checker dut (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .ba(ba), .a10(a10),
    .violValid(violValid), .violCode(violCode),
    .stickyValid(stickyValid), .stickyCode(stickyCode)
  );

  // bench command kinds
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5, C_MRS = 3'd6, C_BST = 3'd7;

  // {kind, bank, a10, expected code}; defaults T_RCD3 T_RAS5 T_RC9 T_RRD2
  // T_RP3 T_WR2 T_WTR2 T_RFC6 T_MRD2, burst of 4 -> 2 data clocks
  localparam int NV = 35;
  localparam logic [9:0] VEC [0:NV-1] = '{
    {C_MRS, 2'd0, 1'b0, 4'd0},   // 0
    {C_REF, 2'd0, 1'b0, 4'd1},   // 1  R3
    {C_NOP, 2'd0, 1'b0, 4'd0},   // 2
    {C_BST, 2'd0, 1'b0, 4'd2},   // 3  R4 R14
    {C_NOP, 2'd0, 1'b0, 4'd0},   // 4
    {C_NOP, 2'd0, 1'b0, 4'd0},   // 5
    {C_NOP, 2'd0, 1'b0, 4'd0},   // 6
    {C_ACT, 2'd0, 1'b0, 4'd0},   // 7
    {C_ACT, 2'd1, 1'b0, 4'd9},   // 8  R8 rrd
    {C_RD,  2'd0, 1'b0, 4'd6},   // 9  R7 rcd
    {C_RD,  2'd0, 1'b0, 4'd0},   // 10
    {C_ACT, 2'd0, 1'b0, 4'd5},   // 11 R6 + R13 (5 over 8)
    {C_WR,  2'd1, 1'b0, 4'd0},   // 12
    {C_NOP, 2'd0, 1'b0, 4'd0},   // 13
    {C_RD,  2'd0, 1'b0, 4'd12},  // 14 R10 wtr
    {C_PRE, 2'd1, 1'b0, 4'd11},  // 15 R10 wr
    {C_NOP, 2'd0, 1'b0, 4'd0},   // 16
    {C_ACT, 2'd1, 1'b0, 4'd10},  // 17 R9
    {C_PRE, 2'd0, 1'b0, 4'd0},   // 18
    {C_RD,  2'd2, 1'b0, 4'd4},   // 19 R6 closed
    {C_REF, 2'd0, 1'b0, 4'd3},   // 20 R5
    {C_PRE, 2'd1, 1'b1, 4'd2},   // 21 R4 + R13 (2 over 7)
    {C_NOP, 2'd0, 1'b0, 4'd0},   // 22
    {C_NOP, 2'd0, 1'b0, 4'd0},   // 23
    {C_NOP, 2'd0, 1'b0, 4'd0},   // 24
    {C_NOP, 2'd0, 1'b0, 4'd0},   // 25
    {C_ACT, 2'd3, 1'b0, 4'd0},   // 26
    {C_NOP, 2'd0, 1'b0, 4'd0},   // 27
    {C_ACT, 2'd2, 1'b0, 4'd0},   // 28
    {C_WR,  2'd3, 1'b1, 4'd0},   // 29 write with auto precharge
    {C_NOP, 2'd0, 1'b0, 4'd0},   // 30
    {C_WR,  2'd2, 1'b0, 4'd13},  // 31 R11
    {C_NOP, 2'd0, 1'b0, 4'd0},   // 32
    {C_ACT, 2'd3, 1'b0, 4'd8},   // 33 R8 + R9 + R13 (8 over 10)
    {C_NOP, 2'd0, 1'b0, 4'd0}    // 34 R2 clears
  };

  task automatic drive(input logic [2:0] kind, input logic [1:0] bank,
                       input logic ap);
    csN = 1'b0;
    ba  = bank;
    a10 = ap;
    case (kind)
      C_ACT:   {rasN, casN, weN} = 3'b011;
      C_RD:    {rasN, casN, weN} = 3'b101;
      C_WR:    {rasN, casN, weN} = 3'b100;
      C_PRE:   {rasN, casN, weN} = 3'b010;
      C_REF:   {rasN, casN, weN} = 3'b001;
      C_MRS:   {rasN, casN, weN} = 3'b000;
      C_BST:   {rasN, casN, weN} = 3'b110;
      default: {rasN, casN, weN} = 3'b111;
    endcase
  endtask

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // called at a falling edge: drive, wait one cycle, check result
  task automatic runCmd(input logic [2:0] kind, input logic [1:0] bank,
                        input logic ap, input int exp, input string req);
    drive(kind, bank, ap);
    @(negedge clk);
    check({req, " code"}, violCode, exp);
    check({req, " valid"}, violValid, exp != 0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    cke  = 1'b1;
    drive(C_NOP, 2'd0, 1'b0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    doReset();
    // R2: reset state
    check("R2 reset valid", violValid, 0);
    check("R2 reset code", violCode, 0);
    check("R13 reset sticky", stickyValid, 0);
    runCmd(C_NOP, 2'd0, 1'b0, 0, "R1 nop");

    for (int i = 0; i < NV; i++) begin
      runCmd(VEC[i][9:7], VEC[i][6:5], VEC[i][4], int'(VEC[i][3:0]),
             $sformatf("R2 vec%0d", i));
    end

    // R13: first violation (vector 1, code 1) held
    check("R13 sticky valid", stickyValid, 1);
    check("R13 sticky code", stickyCode, 1);

    // R2: reset clears everything again
    doReset();
    check("R2 rereset sticky", stickyValid, 0);
    check("R2 rereset code", violCode, 0);
    runCmd(C_NOP, 2'd0, 1'b0, 0, "R1 nop");

    // R1: activate with clock enable low is ignored
    cke = 1'b0;
    runCmd(C_ACT, 2'd0, 1'b0, 0, "R1 cke low");
    cke = 1'b1;
    runCmd(C_NOP, 2'd0, 1'b0, 0, "R1 cke back");
    runCmd(C_RD, 2'd0, 1'b0, 4, "R1 ignored activate");
    // R1: deselected activate is ignored
    drive(C_ACT, 2'd1, 1'b0);
    csN = 1'b1;
    @(negedge clk);
    check("R1 deselect", violCode, 0);
    runCmd(C_RD, 2'd1, 1'b0, 4, "R1 ignored deselect");
    check("R13 sticky second", stickyCode, 4);

    // R12: precharge-all ignores ba and closes every bank
    runCmd(C_ACT, 2'd0, 1'b0, 0, "R12 open0");
    runCmd(C_NOP, 2'd0, 1'b0, 0, "R12 gap");
    runCmd(C_ACT, 2'd2, 1'b0, 0, "R12 open2");
    for (int k = 0; k < 5; k++) runCmd(C_NOP, 2'd0, 1'b0, 0, "R12 wait");
    runCmd(C_PRE, 2'd1, 1'b1, 0, "R12 pre all");
    runCmd(C_RD, 2'd0, 1'b0, 4, "R12 bank0 closed");
    runCmd(C_RD, 2'd2, 1'b0, 4, "R12 bank2 closed");
    // R14: burst stop alone is legal
    runCmd(C_BST, 2'd3, 1'b0, 0, "R14 burst stop");
    // R7: precharge of open bank too soon after activate
    runCmd(C_ACT, 2'd1, 1'b0, 0, "R7 open1");
    runCmd(C_NOP, 2'd0, 1'b0, 0, "R7 gap");
    runCmd(C_PRE, 2'd1, 1'b0, 7, "R7 ras");

    finishRun();
  end

endmodule